// File: doc/BRIEF.md
# Temperature Excursion Logger

This block watches a stream of mission temperature samples and keeps a record of every excursion outside a programmable band. Each sample byte arrives with a one-cycle valid strobe. It is compared with a low and a high threshold byte. A sample at or below the low threshold counts as a low alarm. A sample at or above the high threshold counts as a high alarm. The low and high directions are tracked by two independent copies of the same tracker.

When an excursion starts, the tracker claims the next free event slot. It writes the current mission sample count into that slot as a time stamp, followed by a one-byte duration. Each further sample outside the band raises the duration by one. When the duration reaches its maximum and the excursion continues, the tracker opens a new slot with a fresh stamp. When the sample comes back inside the band, the duration stops changing, and a later excursion takes the next free slot.

Slot writes leave the block through a single word-wide write port with byte enables, one slot per word. Two sticky flags show that a low or a high alarm has been seen. The host can only clear these flags. Valid samples must be at least two cycles apart, because the write port is shared.

Top module: `temp_excursion_logger`

## Requirements
- R1: A sample is a low alarm when it is less than or equal to `thr_lo`. It is a high alarm when it is greater than or equal to `thr_hi`. Both comparisons are unsigned.
- R2: The first alarm sample of an excursion produces one write in the cycle after the strobe. The write has `ev_be` = 4'b1111. Data bits [23:0] hold `smp_count`, least significant byte in bits [7:0] (lowest byte address). Bits [31:24] hold a duration of 1.
- R3: Each further alarm sample of the same excursion writes the same slot with `ev_be` = 4'b1000. Data bits [31:24] hold the previous duration plus one.
- R4: If the duration is 255 and the next sample is still an alarm in that direction, the write goes to the next slot with `ev_be` = 4'b1111. It carries the current `smp_count` and a duration of 1.
- R5: A sample back inside the band causes no write for that direction. The next excursion in that direction uses the following slot.
- R6: Slot i (i = 0 to 11) is at byte address 4*i for the low direction and 48 + 4*i for the high direction, on `ev_addr`.
- R7: When all 12 slots of a direction are used, further excursions in that direction write nothing, but they still set that direction's flag.
- R8: `flag_lo` and `flag_hi` rise on the edge that takes an alarm sample of their direction. They fall only on a clear strobe. A clear in the same cycle as an alarm sample of the same direction leaves the flag set.
- R9: When one sample is both a low and a high alarm, the low-direction write appears in the cycle after the strobe. The high-direction write appears in the cycle after that.
- R10: After reset both flags are 0, `ev_we` is 0 and every direction starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe for a new sample, at least two cycles apart |
| smp_value | input | SMP_W | Sample value, unsigned |
| thr_lo | input | SMP_W | Low threshold, inclusive |
| thr_hi | input | SMP_W | High threshold, inclusive |
| smp_count | input | STAMP_W | Current mission sample count, used as the stamp |
| clr_lo_flag | input | 1 | Clears the low alarm flag |
| clr_hi_flag | input | 1 | Clears the high alarm flag |
| ev_we | output | 1 | Event memory write enable |
| ev_addr | output | ADDR_W | Byte address of the slot written |
| ev_be | output | (STAMP_W+DUR_W)/8 | Byte enables, bit i for byte address ev_addr+i |
| ev_wdata | output | STAMP_W+DUR_W | Slot word: stamp in the low bytes, duration in the top byte |
| flag_lo | output | 1 | Sticky low alarm flag |
| flag_hi | output | 1 | Sticky high alarm flag |

## Verification
Both trackers can want the write port in the same cycle. This happens when one sample is an alarm in both directions, which is possible only when the low threshold is set at or above the high threshold. The bench sets an inverted band to provoke it. The scoreboard expects the low-slot write first and the high-slot write in the next cycle, and any reordering or lost write shows up as a mismatch. The bench also puts a flag clear in the same cycle as an alarm sample and expects the flag to stay set.

// File: rtl/tel_pkg.sv
package tel_pkg;
   typedef enum logic {DIR_LO = 1'b0, DIR_HI = 1'b1} dir_e;
endpackage

// File: rtl/tel_cmp.sv
module tel_cmp #(
   parameter int SMP_W = 8
) (
   input  logic [SMP_W-1:0] smp,
   input  logic [SMP_W-1:0] thr_lo,
   input  logic [SMP_W-1:0] thr_hi,
   output logic             lo_hit,
   output logic             hi_hit
);
   // Both comparisons include the threshold value itself (R1)
   always_comb begin
      lo_hit = (smp <= thr_lo);
      hi_hit = (smp >= thr_hi);
   end
endmodule

// File: rtl/tel_track.sv
module tel_track
   import tel_pkg::*;
#(
   parameter dir_e DIR     = DIR_LO,
   parameter int   STAMP_W = 24,
   parameter int   DUR_W   = 8,
   parameter int   NSLOT   = 12,
   parameter int   ADDR_W  = 7,
   parameter int   BASE    = 0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             smp_valid,
   input  logic                             hit,
   input  logic [STAMP_W-1:0]               stamp,
   input  logic                             clr_flag,
   output logic                             req,
   output logic [ADDR_W-1:0]                req_addr,
   output logic [(STAMP_W+DUR_W)/8-1:0]     req_be,
   output logic [STAMP_W+DUR_W-1:0]         req_data,
   output logic                             flag
);
   localparam int WORD_W   = STAMP_W + DUR_W;
   localparam int BE_W     = WORD_W / 8;
   localparam int STAMP_B  = STAMP_W / 8;
   localparam int SLOT_W   = $clog2(NSLOT + 1);
   localparam int DIR_BASE = BASE + ((DIR == DIR_HI) ? NSLOT * BE_W : 0);
   localparam logic [SLOT_W-1:0] SLOT_LIM = SLOT_W'(NSLOT);
   localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);
   localparam logic [DUR_W-1:0]  DUR_MAX  = '1;
   localparam logic [DUR_W-1:0]  DUR_ONE  = DUR_W'(1);
   localparam logic [BE_W-1:0]   BE_ALL   = '1;
   localparam logic [BE_W-1:0]   BE_DUR   = BE_ALL << STAMP_B;

   logic [SLOT_W-1:0] nxt_q;
   logic              act_q;
   logic [DUR_W-1:0]  dur_q;
   logic              flag_q;
   logic              req_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BE_W-1:0]   be_q;
   logic [WORD_W-1:0] data_q;

   logic              alarm, room, opening, bumping;
   logic [SLOT_W-1:0] slot;

   always_comb begin
      alarm   = smp_valid && hit;
      room    = (nxt_q < SLOT_LIM);
      opening = alarm && (!act_q || (dur_q == DUR_MAX)) && room;
      bumping = alarm && act_q && (dur_q != DUR_MAX);
      slot    = opening ? nxt_q : (nxt_q - SLOT_ONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nxt_q  <= '0;
         act_q  <= 1'b0;
         dur_q  <= '0;
         flag_q <= 1'b0;
         req_q  <= 1'b0;
         addr_q <= '0;
         be_q   <= '0;
         data_q <= '0;
      end else begin
         req_q <= opening || bumping;
         if (opening || bumping) begin
            addr_q <= ADDR_W'(DIR_BASE) + ADDR_W'(slot) * ADDR_W'(BE_W);
            be_q   <= opening ? BE_ALL : BE_DUR;
            data_q <= {(opening ? DUR_ONE : dur_q + DUR_ONE), stamp};
         end
         if (opening) begin
            act_q <= 1'b1;
            dur_q <= DUR_ONE;
            nxt_q <= nxt_q + SLOT_ONE;
         end else if (bumping) begin
            dur_q <= dur_q + DUR_ONE;
         end else if (smp_valid) begin
            act_q <= 1'b0;
         end
         if (alarm)         flag_q <= 1'b1;
         else if (clr_flag) flag_q <= 1'b0;
      end
   end

   assign req      = req_q;
   assign req_addr = addr_q;
   assign req_be   = be_q;
   assign req_data = data_q;
   assign flag     = flag_q;

   p_dur_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm && act_q && dur_q != DUR_MAX) |=> (dur_q == $past(dur_q) + DUR_ONE));
   p_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm && act_q && dur_q == DUR_MAX && room)
      |=> (req_q && be_q == BE_ALL && dur_q == DUR_ONE && nxt_q == $past(nxt_q) + SLOT_ONE));
   p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !hit) |=> (!req_q && !act_q));
   p_slot_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nxt_q <= SLOT_LIM);
   p_full_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!room && !act_q) |=> !req_q);
   p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      alarm |=> flag_q);
   p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm && !clr_flag) |=> $stable(flag_q));
   p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm && clr_flag) |=> !flag_q);
endmodule

// File: rtl/tel_arb.sv
module tel_arb #(
   parameter int ADDR_W = 7,
   parameter int WORD_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  a_req,
   input  logic [ADDR_W-1:0]     a_addr,
   input  logic [WORD_W/8-1:0]   a_be,
   input  logic [WORD_W-1:0]     a_data,
   input  logic                  b_req,
   input  logic [ADDR_W-1:0]     b_addr,
   input  logic [WORD_W/8-1:0]   b_be,
   input  logic [WORD_W-1:0]     b_data,
   output logic                  we,
   output logic [ADDR_W-1:0]     addr,
   output logic [WORD_W/8-1:0]   be,
   output logic [WORD_W-1:0]     data
);
   localparam int BE_W = WORD_W / 8;

   logic              pend_q;
   logic [ADDR_W-1:0] p_addr;
   logic [BE_W-1:0]   p_be;
   logic [WORD_W-1:0] p_data;

   // Port a (low direction) goes first; a colliding b request waits one cycle
   always_comb begin
      we   = a_req || pend_q || b_req;
      addr = b_addr;
      be   = b_be;
      data = b_data;
      if (a_req) begin
         addr = a_addr;
         be   = a_be;
         data = a_data;
      end else if (pend_q) begin
         addr = p_addr;
         be   = p_be;
         data = p_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         p_addr <= '0;
         p_be   <= '0;
         p_data <= '0;
      end else begin
         pend_q <= a_req && b_req;
         if (a_req && b_req) begin
            p_addr <= b_addr;
            p_be   <= b_be;
            p_data <= b_data;
         end
      end
   end

   p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !(a_req || b_req));
   p_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_req && b_req) |=> (we && addr == $past(b_addr) && be == $past(b_be)));
endmodule

// File: rtl/temp_excursion_logger.sv
module temp_excursion_logger
   import tel_pkg::*;
#(
   parameter int SMP_W   = 8,
   parameter int STAMP_W = 24,
   parameter int DUR_W   = 8,
   parameter int NSLOT   = 12,
   parameter int ADDR_W  = 7,
   parameter int BASE    = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         smp_valid,
   input  logic [SMP_W-1:0]             smp_value,
   input  logic [SMP_W-1:0]             thr_lo,
   input  logic [SMP_W-1:0]             thr_hi,
   input  logic [STAMP_W-1:0]           smp_count,
   input  logic                         clr_lo_flag,
   input  logic                         clr_hi_flag,
   output logic                         ev_we,
   output logic [ADDR_W-1:0]            ev_addr,
   output logic [(STAMP_W+DUR_W)/8-1:0] ev_be,
   output logic [STAMP_W+DUR_W-1:0]     ev_wdata,
   output logic                         flag_lo,
   output logic                         flag_hi
);
   localparam int WORD_W = STAMP_W + DUR_W;
   localparam int BE_W   = WORD_W / 8;
   localparam int NDIR   = 2;

   if ((STAMP_W % 8) != 0 || (DUR_W % 8) != 0) begin : g_bad_width
      $error("stamp and duration widths must be whole bytes");
   end
   if (NSLOT < 1) begin : g_bad_slots
      $error("at least one slot per direction is needed");
   end
   if (BASE + NDIR * NSLOT * BE_W > (1 << ADDR_W)) begin : g_bad_addr
      $error("event area does not fit the address width");
   end

   logic [NDIR-1:0]   hits, clrs, reqs, flags;
   logic [ADDR_W-1:0] t_addr [NDIR];
   logic [BE_W-1:0]   t_be   [NDIR];
   logic [WORD_W-1:0] t_data [NDIR];

   tel_cmp #(.SMP_W(SMP_W)) u_cmp (
      .smp    (smp_value),
      .thr_lo (thr_lo),
      .thr_hi (thr_hi),
      .lo_hit (hits[0]),
      .hi_hit (hits[1])
   );

   assign clrs = {clr_hi_flag, clr_lo_flag};

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      tel_track #(
         .DIR     (dir_e'(d)),
         .STAMP_W (STAMP_W),
         .DUR_W   (DUR_W),
         .NSLOT   (NSLOT),
         .ADDR_W  (ADDR_W),
         .BASE    (BASE)
      ) u_trk (
         .clk       (clk),
         .rst_n     (rst_n),
         .smp_valid (smp_valid),
         .hit       (hits[d]),
         .stamp     (smp_count),
         .clr_flag  (clrs[d]),
         .req       (reqs[d]),
         .req_addr  (t_addr[d]),
         .req_be    (t_be[d]),
         .req_data  (t_data[d]),
         .flag      (flags[d])
      );
   end

   tel_arb #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_req  (reqs[0]),
      .a_addr (t_addr[0]),
      .a_be   (t_be[0]),
      .a_data (t_data[0]),
      .b_req  (reqs[1]),
      .b_addr (t_addr[1]),
      .b_be   (t_be[1]),
      .b_data (t_data[1]),
      .we     (ev_we),
      .addr   (ev_addr),
      .be     (ev_be),
      .data   (ev_wdata)
   );

   assign flag_lo = flags[0];
   assign flag_hi = flags[1];

   // Usage rule behind the shared port (R9): strobes at least two cycles apart
   p_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> !smp_valid);
   p_reset_idle_r10: assert property (@(posedge clk)
      !rst_n |=> (!ev_we && !flag_lo && !flag_hi));
endmodule

// File: tb/temp_excursion_logger_test.sv
`timescale 1ns/1ps
module temp_excursion_logger_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [7:0]  smp_value = '0;
   logic [7:0]  thr_lo = 8'd40;
   logic [7:0]  thr_hi = 8'd200;
   logic [23:0] smp_count = '0;
   logic        clr_lo_flag = 1'b0;
   logic        clr_hi_flag = 1'b0;
   logic        ev_we;
   logic [6:0]  ev_addr;
   logic [3:0]  ev_be;
   logic [31:0] ev_wdata;
   logic        flag_lo, flag_hi;

   always #4 clk = ~clk;

   temp_excursion_logger uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_value(smp_value),
      .thr_lo(thr_lo), .thr_hi(thr_hi), .smp_count(smp_count),
      .clr_lo_flag(clr_lo_flag), .clr_hi_flag(clr_hi_flag),
      .ev_we(ev_we), .ev_addr(ev_addr), .ev_be(ev_be), .ev_wdata(ev_wdata),
      .flag_lo(flag_lo), .flag_hi(flag_hi)
   );

   int checks = 0;
   int fails = 0;
   int writes_seen = 0;
   bit done = 0;

   logic [42:0] exp_q[$];
   string       tag_q[$];

   int          nf [2];
   int          dur [2];
   bit          act [2];
   bit          fl [2];
   logic [23:0] cnt = 24'h010203;

   task automatic chk(input string tag, input logic [63:0] a, input logic [63:0] e);
      checks++;
      if (a !== e) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
      end
   endtask

   task automatic push_exp(input string tag, input int addr, input logic [3:0] be,
                           input logic [31:0] data);
      exp_q.push_back({7'(addr), be, data});
      tag_q.push_back(tag);
   endtask

   // Scoreboard monitor: pops one expected write per observed write
   always @(negedge clk) begin
      if (rst_n && ev_we) begin
         writes_seen++;
         if (exp_q.size() == 0) begin
            chk("R5 unexpected write", {25'd0, ev_addr, ev_be, ev_wdata}, 64'd0);
         end else begin
            logic [42:0] e;
            string       t;
            logic [31:0] m;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            m = '0;
            for (int i = 0; i < 4; i++) if (e[32+i]) m[8*i +: 8] = 8'hFF;
            chk({t, " addr"}, 64'(ev_addr), 64'(e[42:36]));
            chk({t, " be"}, 64'(ev_be), 64'(e[35:32]));
            chk({t, " data"}, 64'(ev_wdata & m), 64'(e[31:0] & m));
         end
      end
   end

   // Reference model from the requirements, then drive one strobe
   task automatic do_sample(input logic [7:0] v, input bit cl = 0, input bit ch = 0);
      bit hit [2];
      bit clr [2];
      hit[0] = (v <= thr_lo);            // R1 inclusive low
      hit[1] = (v >= thr_hi);            // R1 inclusive high
      clr[0] = cl;
      clr[1] = ch;
      for (int d = 0; d < 2; d++) begin
         int base;
         base = d * 48;                  // R6 layout
         if (hit[d]) begin
            if (!act[d] || dur[d] == 255) begin
               if (nf[d] < 12) begin
                  push_exp(act[d] ? "R4 chain" : "R2 open", base + 4 * nf[d], 4'hF,
                           {8'd1, cnt});
                  act[d] = 1;
                  dur[d] = 1;
                  nf[d]++;
               end else begin
                  act[d] = 0;            // R7 no room
               end
            end else begin
               dur[d]++;
               push_exp("R3 extend", base + 4 * (nf[d] - 1), 4'h8, {8'(dur[d]), cnt});
            end
            fl[d] = 1;
         end else begin
            act[d] = 0;                  // R5 back in band
            if (clr[d]) fl[d] = 0;
         end
      end
      @(negedge clk);
      smp_value   = v;
      smp_count   = cnt;
      smp_valid   = 1'b1;
      clr_lo_flag = cl;
      clr_hi_flag = ch;
      @(negedge clk);
      smp_valid   = 1'b0;
      clr_lo_flag = 1'b0;
      clr_hi_flag = 1'b0;
      chk("R8 flag_lo", 64'(flag_lo), 64'(fl[0]));
      chk("R8 flag_hi", 64'(flag_hi), 64'(fl[1]));
      cnt = cnt + 24'd1;
   endtask

   task automatic do_clear(input bit cl, input bit ch);
      @(negedge clk);
      clr_lo_flag = cl;
      clr_hi_flag = ch;
      @(negedge clk);
      clr_lo_flag = 1'b0;
      clr_hi_flag = 1'b0;
      if (cl) fl[0] = 0;
      if (ch) fl[1] = 0;
      chk("R8 clear lo", 64'(flag_lo), 64'(fl[0]));
      chk("R8 clear hi", 64'(flag_hi), 64'(fl[1]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int ws;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 flag_lo", 64'(flag_lo), 64'd0);
      chk("R10 flag_hi", 64'(flag_hi), 64'd0);
      chk("R10 we", 64'(ev_we), 64'd0);

      // R1 boundaries and R2/R3/R5/R6 basics
      do_sample(8'd100);
      do_sample(8'd41);                  // R1 just above low threshold
      do_sample(8'd199);                 // R1 just below high threshold
      do_sample(8'd40);                  // R1 equal to low: opens low slot 0
      do_sample(8'd30);                  // R3 duration 2
      do_sample(8'd0);                   // R3 duration 3
      do_sample(8'd41);                  // R5 return
      do_sample(8'd39);                  // R5 next slot 1
      do_sample(8'd200);                 // R1 equal to high: high slot 0 at 48 (R6)
      do_sample(8'd255);
      do_clear(1, 1);                    // R8 host clear
      do_sample(8'd10, 1, 0);            // R8 clear with alarm: set wins
      do_sample(8'd100);

      // R4 duration overflow chains into a new slot
      for (int i = 0; i < 257; i++) do_sample(8'd220);
      do_sample(8'd100);

      // R9 inverted band: one sample alarms both directions
      thr_lo = 8'd150;
      thr_hi = 8'd100;
      do_sample(8'd120);
      do_sample(8'd120);
      thr_lo = 8'd40;
      thr_hi = 8'd200;
      do_sample(8'd120);

      // R7 fill the low slots, then one more excursion
      while (nf[0] < 12) begin
         do_sample(8'd20);
         do_sample(8'd100);
      end
      do_clear(1, 0);
      repeat (3) @(negedge clk);
      ws = writes_seen;
      do_sample(8'd5);
      repeat (3) @(negedge clk);
      chk("R7 no write when full", 64'(writes_seen), 64'(ws));
      chk("R7 flag still set", 64'(flag_lo), 64'd1);

      repeat (4) @(negedge clk);
      chk("R9 scoreboard drained", 64'(exp_q.size()), 64'd0);
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule